// File: doc/BRIEF.md
# Trap-Return Status Update Unit

This unit carries out the two privileged return instructions of a processor core: the return from a supervisor trap handler and the return from a machine trap handler. The core raises `ret_valid` for one cycle. With it the core presents the current privilege level, the virtualization flag, the relevant status fields, both saved exception PCs and a set of configuration flags. One cycle later the unit gives back the new privilege and virtualization mode, the updated status vectors, the return PC and the expected-landing-pad flag. If the return is not permitted, it instead reports a fault with a cause code.

All legality checks are settled before any state is computed. A faulting return therefore hands back the incoming status, privilege, mode and landing-pad flag unchanged, so the core may write the outputs back without a special case. The outputs hold their values between requests.

Top module: `trap_return_unit`

## Requirements
- R1: Privilege encoding is user=0, supervisor=1, machine=3. `done` is high for exactly the one cycle after a cycle with `ret_valid` high. After reset every output is zero. Outputs change only in the cycle after a request.
- R2: A supervisor return at user privilege faults, and so does a machine return at any privilege other than machine. Fault cause codes are 0 illegal instruction, 1 virtual instruction, 2 misaligned return address, 3 instruction access fault.
- R3: When `has_cext` is low and either of bits 1:0 of the selected return PC is set, the return faults with cause 2. When `has_cext` is high, those bits cause no fault.
- R4: A supervisor return below machine privilege with the trap-return status bit (status bit 9) set faults with cause 0. If that bit does not fault the return and `cur_virt` is high with hypervisor bit 1 set, the return faults with cause 1.
- R5: Status vector bit positions are: 0 SIE, 1 MIE, 2 SPIE, 3 MPIE, 4 SPP, 6:5 MPP, 7 MPRV, 8 MPV, 9 trap-return, 10 SPELP, 11 MPELP. Hypervisor vector bit 0 is SPV and bit 1 is virtual-trap-return. A supervisor return copies SPIE to SIE, sets SPIE, clears SPP and sets the new privilege to the old SPP.
- R6: A machine return copies MPIE to MIE, sets MPIE, clears MPV, and writes MPP with user when `has_umode` is high and with machine otherwise. The new privilege is the old MPP.
- R7: On a machine return the new virtualization mode is the old MPV, forced to 0 when the old MPP is machine.
- R8: When `new_spec` is high, MPRV is cleared by every successful supervisor return. It is also cleared by every successful machine return whose old MPP is not machine. In all other cases MPRV is kept.
- R9: On a supervisor return with `has_hyp` high and `cur_virt` low, the new virtualization mode is SPV and SPV is cleared. Otherwise the mode and SPV are kept.
- R10: When `pmp_empty` is high, a machine return whose old MPP is not machine faults with cause 3.
- R11: A successful return copies its saved landing-pad bit (SPELP or MPELP) to `elp_out` only when `cfi_en` is high, and otherwise passes `elp_in` through. That saved bit is always cleared.
- R12: Checks apply in this priority: privilege, then misalignment, then trap-return bit or empty PMP, then virtual-trap-return. On a fault the status, privilege, mode and landing-pad outputs equal the request's inputs and `ret_pc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | Return request, one cycle |
| ret_is_mret | input | 1 | 1 machine return, 0 supervisor return |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Current virtualization flag |
| mst_in | input | 12 | Machine status fields |
| hst_in | input | 2 | Hypervisor status fields |
| sepc | input | XLEN | Saved supervisor exception PC |
| mepc | input | XLEN | Saved machine exception PC |
| elp_in | input | 1 | Current expected-landing-pad flag |
| has_cext | input | 1 | Compressed instructions present |
| has_umode | input | 1 | User mode present |
| has_hyp | input | 1 | Hypervisor support present |
| pmp_empty | input | 1 | PMP implemented with zero rules |
| new_spec | input | 1 | MPRV clearing on return enabled |
| cfi_en | input | 1 | Forward CFI enabled for target privilege |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Return faulted |
| fault_cause | output | 2 | Fault cause code |
| priv_out | output | 2 | New privilege |
| virt_out | output | 1 | New virtualization flag |
| mst_out | output | 12 | Updated machine status fields |
| hst_out | output | 2 | Updated hypervisor status fields |
| ret_pc | output | XLEN | Return PC |
| elp_out | output | 1 | New expected-landing-pad flag |

## Verification
The bench aims at fault priority, since a design with the checks in the wrong order would report a misaligned or virtual-instruction cause where an illegal one belongs. It toggles the MPP=machine cases, where a wrong design would keep a stale MPV, clear MPRV or raise an access fault with an empty PMP. It checks supervisor returns from virtualized and non-hypervisor states, where a wrong design would clear SPV or change the mode. It also checks that a faulting return changes nothing, including the landing-pad flag.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int STW = 12;
  localparam int HSW = 2;

  localparam int B_SIE   = 0;
  localparam int B_MIE   = 1;
  localparam int B_SPIE  = 2;
  localparam int B_MPIE  = 3;
  localparam int B_SPP   = 4;
  localparam int B_MPP   = 5;
  localparam int B_MPRV  = 7;
  localparam int B_MPV   = 8;
  localparam int B_TSR   = 9;
  localparam int B_SPELP = 10;
  localparam int B_MPELP = 11;

  localparam int H_SPV  = 0;
  localparam int H_VTSR = 1;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    CAUSE_ILLEGAL  = 2'd0,
    CAUSE_VIRT     = 2'd1,
    CAUSE_MISALIGN = 2'd2,
    CAUSE_ACCESS   = 2'd3
  } cause_e;
endpackage

// File: rtl/trp_fault_check.sv
module trp_fault_check
  import trp_pkg::*;
(
  input  logic       is_mret,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       tsr,
  input  logic       vtsr,
  input  logic [1:0] mpp,
  input  logic [1:0] pc_low,
  input  logic       has_cext,
  input  logic       pmp_empty,
  output logic       fault,
  output cause_e     cause
);
  always_comb begin
    fault = 1'b0;
    cause = CAUSE_ILLEGAL;
    if (is_mret) begin
      if (priv != PRIV_M) begin
        fault = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (!has_cext && (pc_low != 2'b00)) begin
        fault = 1'b1; cause = CAUSE_MISALIGN;
      end else if (pmp_empty && (mpp != PRIV_M)) begin
        fault = 1'b1; cause = CAUSE_ACCESS;
      end
    end else begin
      if (priv == PRIV_U) begin
        fault = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (!has_cext && (pc_low != 2'b00)) begin
        fault = 1'b1; cause = CAUSE_MISALIGN;
      end else if (tsr && (priv != PRIV_M)) begin
        fault = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (virt && vtsr) begin
        fault = 1'b1; cause = CAUSE_VIRT;
      end
    end
  end
endmodule

// File: rtl/trp_sret_next.sv
module trp_sret_next
  import trp_pkg::*;
(
  input  logic [STW-1:0] mst,
  input  logic [HSW-1:0] hst,
  input  logic           virt,
  input  logic           elp,
  input  logic           has_hyp,
  input  logic           new_spec,
  input  logic           cfi_en,
  output logic [STW-1:0] mst_nx,
  output logic [HSW-1:0] hst_nx,
  output logic [1:0]     priv_nx,
  output logic           virt_nx,
  output logic           elp_nx
);
  always_comb begin
    mst_nx          = mst;
    hst_nx          = hst;
    priv_nx         = {1'b0, mst[B_SPP]};
    virt_nx         = virt;
    mst_nx[B_SIE]   = mst[B_SPIE];
    mst_nx[B_SPIE]  = 1'b1;
    mst_nx[B_SPP]   = 1'b0;
    if (new_spec) mst_nx[B_MPRV] = 1'b0;
    if (has_hyp && !virt) begin
      virt_nx       = hst[H_SPV];
      hst_nx[H_SPV] = 1'b0;
    end
    elp_nx          = cfi_en ? mst[B_SPELP] : elp;
    mst_nx[B_SPELP] = 1'b0;
  end
endmodule

// File: rtl/trp_mret_next.sv
module trp_mret_next
  import trp_pkg::*;
(
  input  logic [STW-1:0] mst,
  input  logic           elp,
  input  logic           has_umode,
  input  logic           new_spec,
  input  logic           cfi_en,
  output logic [STW-1:0] mst_nx,
  output logic [1:0]     priv_nx,
  output logic           virt_nx,
  output logic           elp_nx
);
  logic [1:0] old_mpp;
  logic       to_m;

  always_comb begin
    old_mpp = mst[B_MPP +: 2];
    to_m    = (old_mpp == PRIV_M);
    mst_nx  = mst;
    priv_nx = old_mpp;
    virt_nx = mst[B_MPV] && !to_m;
    mst_nx[B_MIE]      = mst[B_MPIE];
    mst_nx[B_MPIE]     = 1'b1;
    mst_nx[B_MPP +: 2] = has_umode ? PRIV_U : PRIV_M;
    mst_nx[B_MPV]      = 1'b0;
    if (new_spec && !to_m) mst_nx[B_MPRV] = 1'b0;
    elp_nx             = cfi_en ? mst[B_MPELP] : elp;
    mst_nx[B_MPELP]    = 1'b0;
  end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_valid,
  input  logic            ret_is_mret,
  input  logic [1:0]      cur_priv,
  input  logic            cur_virt,
  input  logic [11:0]     mst_in,
  input  logic [1:0]      hst_in,
  input  logic [XLEN-1:0] sepc,
  input  logic [XLEN-1:0] mepc,
  input  logic            elp_in,
  input  logic            has_cext,
  input  logic            has_umode,
  input  logic            has_hyp,
  input  logic            pmp_empty,
  input  logic            new_spec,
  input  logic            cfi_en,
  output logic            done,
  output logic            fault,
  output logic [1:0]      fault_cause,
  output logic [1:0]      priv_out,
  output logic            virt_out,
  output logic [11:0]     mst_out,
  output logic [1:0]      hst_out,
  output logic [XLEN-1:0] ret_pc,
  output logic            elp_out
);
  logic [XLEN-1:0] pc_sel;
  logic            flt_c;
  cause_e          cause_c;

  logic [STW-1:0]  s_mst, m_mst, mst_d, mst_q;
  logic [HSW-1:0]  s_hst, hst_d, hst_q;
  logic [1:0]      s_priv, m_priv, priv_d, priv_q;
  logic            s_virt, m_virt, virt_d, virt_q;
  logic            s_elp, m_elp, elp_d, elp_q;
  logic [XLEN-1:0] pc_d, pc_q;
  logic            done_q, flt_q;
  logic [1:0]      cause_q;

  assign pc_sel = ret_is_mret ? mepc : sepc;

  trp_fault_check u_chk (
    .is_mret   (ret_is_mret),
    .priv      (cur_priv),
    .virt      (cur_virt),
    .tsr       (mst_in[B_TSR]),
    .vtsr      (hst_in[H_VTSR]),
    .mpp       (mst_in[B_MPP +: 2]),
    .pc_low    (pc_sel[1:0]),
    .has_cext  (has_cext),
    .pmp_empty (pmp_empty),
    .fault     (flt_c),
    .cause     (cause_c)
  );

  trp_sret_next u_sret (
    .mst      (mst_in),
    .hst      (hst_in),
    .virt     (cur_virt),
    .elp      (elp_in),
    .has_hyp  (has_hyp),
    .new_spec (new_spec),
    .cfi_en   (cfi_en),
    .mst_nx   (s_mst),
    .hst_nx   (s_hst),
    .priv_nx  (s_priv),
    .virt_nx  (s_virt),
    .elp_nx   (s_elp)
  );

  trp_mret_next u_mret (
    .mst       (mst_in),
    .elp       (elp_in),
    .has_umode (has_umode),
    .new_spec  (new_spec),
    .cfi_en    (cfi_en),
    .mst_nx    (m_mst),
    .priv_nx   (m_priv),
    .virt_nx   (m_virt),
    .elp_nx    (m_elp)
  );

  always_comb begin
    if (flt_c) begin
      mst_d  = mst_in;
      hst_d  = hst_in;
      priv_d = cur_priv;
      virt_d = cur_virt;
      elp_d  = elp_in;
      pc_d   = '0;
    end else if (ret_is_mret) begin
      mst_d  = m_mst;
      hst_d  = hst_in;
      priv_d = m_priv;
      virt_d = m_virt;
      elp_d  = m_elp;
      pc_d   = pc_sel;
    end else begin
      mst_d  = s_mst;
      hst_d  = s_hst;
      priv_d = s_priv;
      virt_d = s_virt;
      elp_d  = s_elp;
      pc_d   = pc_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= ret_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q   <= 1'b0;
      cause_q <= 2'd0;
      mst_q   <= '0;
      hst_q   <= '0;
      priv_q  <= 2'd0;
      virt_q  <= 1'b0;
      elp_q   <= 1'b0;
      pc_q    <= '0;
    end else if (ret_valid) begin
      flt_q   <= flt_c;
      cause_q <= flt_c ? cause_c : 2'd0;
      mst_q   <= mst_d;
      hst_q   <= hst_d;
      priv_q  <= priv_d;
      virt_q  <= virt_d;
      elp_q   <= elp_d;
      pc_q    <= pc_d;
    end
  end

  assign done        = done_q;
  assign fault       = flt_q;
  assign fault_cause = cause_q;
  assign priv_out    = priv_q;
  assign virt_out    = virt_q;
  assign mst_out     = mst_q;
  assign hst_out     = hst_q;
  assign ret_pc      = pc_q;
  assign elp_out     = elp_q;

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> done); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> $stable(mst_out) && $stable(priv_out)); // R1
  AST_MRET_LOW_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && ret_is_mret && cur_priv != PRIV_M |=> fault && fault_cause == 2'd0); // R2
  AST_SRET_SPIE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !ret_is_mret |=> fault || (mst_out[B_SPIE] && !mst_out[B_SPP])); // R5
  AST_MRET_MPV_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && ret_is_mret |=> fault || (!mst_out[B_MPV] && mst_out[B_MPIE])); // R6
  AST_NO_VIRT_IN_M: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && priv_out == PRIV_M |-> !virt_out); // R7
  AST_ELP_SAVED_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> fault || (!mst_out[B_SPELP] || !mst_out[B_MPELP])); // R11
  AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !fault || (mst_out == $past(mst_in) && priv_out == $past(cur_priv)
                             && ret_pc == '0)); // R12
endmodule

// File: tb/trap_return_unit_test.sv
module trap_return_unit_test;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            ret_valid = 0, ret_is_mret = 0, cur_virt = 0, elp_in = 0;
  logic [1:0]      cur_priv = 0, hst_in = 0;
  logic [11:0]     mst_in = 0;
  logic [XLEN-1:0] sepc = 0, mepc = 0;
  logic has_cext = 1, has_umode = 1, has_hyp = 1, pmp_empty = 0, new_spec = 1, cfi_en = 0;
  logic            done, fault, virt_out, elp_out;
  logic [1:0]      fault_cause, priv_out, hst_out;
  logic [11:0]     mst_out;
  logic [XLEN-1:0] ret_pc;

  int checks = 0;
  int errors = 0;

  trap_return_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_is_mret(ret_is_mret),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .mst_in(mst_in), .hst_in(hst_in),
    .sepc(sepc), .mepc(mepc), .elp_in(elp_in), .has_cext(has_cext),
    .has_umode(has_umode), .has_hyp(has_hyp), .pmp_empty(pmp_empty),
    .new_spec(new_spec), .cfi_en(cfi_en), .done(done), .fault(fault),
    .fault_cause(fault_cause), .priv_out(priv_out), .virt_out(virt_out),
    .mst_out(mst_out), .hst_out(hst_out), .ret_pc(ret_pc), .elp_out(elp_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic mret, input logic [1:0] pr, input logic vt,
                       input logic [11:0] ms, input logic [1:0] hs);
    @(negedge clk);
    ret_is_mret = mret; cur_priv = pr; cur_virt = vt; mst_in = ms; hst_in = hs;
    ret_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic expect_fault(input string tag, input logic [1:0] cause,
                              input logic [11:0] ms, input logic [1:0] pr);
    chk({tag, " done"}, done, 1);
    chk({tag, " fault"}, fault, 1);
    chk({tag, " cause"}, fault_cause, cause);
    chk({tag, " mst kept"}, mst_out, ms);
    chk({tag, " priv kept"}, priv_out, pr);
    chk({tag, " pc zero"}, ret_pc, 0);
  endtask

  task automatic t_reset;
    chk("R1 reset done", done, 0);
    chk("R1 reset mst", mst_out, 0);
    chk("R1 reset pc", ret_pc, 0);
  endtask

  task automatic t_sret_basic;  // R5 R8 R9
    sepc = 64'h8000_1000; has_hyp = 1; new_spec = 1;
    issue(0, 2'd1, 0, 12'h094, 2'b01);
    chk("R5 sret fault", fault, 0);
    chk("R5 sret mst", mst_out, 12'h005);
    chk("R5 sret priv", priv_out, 2'd1);
    chk("R9 sret virt from SPV", virt_out, 1);
    chk("R9 SPV cleared", hst_out, 2'b00);
    chk("R5 sret pc", ret_pc, 64'h8000_1000);
  endtask

  task automatic t_sret_nohyp;  // R5 R8 R9
    has_hyp = 0; new_spec = 0;
    issue(0, 2'd3, 0, 12'h080, 2'b01);
    chk("R8 mprv kept mst", mst_out, 12'h084);
    chk("R5 sret to user", priv_out, 2'd0);
    chk("R9 no hyp virt kept", virt_out, 0);
    chk("R9 no hyp SPV kept", hst_out, 2'b01);
    has_hyp = 1; new_spec = 1;
    issue(0, 2'd1, 1, 12'h014, 2'b01);
    chk("R9 virtualized virt kept", virt_out, 1);
    chk("R9 virtualized SPV kept", hst_out, 2'b01);
  endtask

  task automatic t_mret_basic;  // R6 R7 R8
    mepc = 64'h4000_0200; has_umode = 1;
    issue(1, 2'd3, 0, 12'h1A8, 2'b00);
    chk("R6 mret fault", fault, 0);
    chk("R6 mret mst", mst_out, 12'h00A);
    chk("R6 mret priv", priv_out, 2'd1);
    chk("R7 mret virt from MPV", virt_out, 1);
    chk("R6 mret pc", ret_pc, 64'h4000_0200);
    has_umode = 0;
    issue(1, 2'd3, 0, 12'h1E0, 2'b00);
    chk("R6 R8 mret to M mst", mst_out, 12'h0E8);
    chk("R6 mret to M priv", priv_out, 2'd3);
    chk("R7 virt forced 0", virt_out, 0);
    has_umode = 1;
  endtask

  task automatic t_illegal;  // R2 R12
    issue(0, 2'd0, 0, 12'h014, 2'b00);
    expect_fault("R2 sret at U", 2'd0, 12'h014, 2'd0);
    issue(1, 2'd1, 0, 12'h028, 2'b00);
    expect_fault("R2 mret at S", 2'd0, 12'h028, 2'd1);
  endtask

  task automatic t_misalign;  // R3 R12
    has_cext = 0; sepc = 64'h1002;
    issue(0, 2'd1, 0, 12'h004, 2'b00);
    expect_fault("R3 sret pc bit1", 2'd2, 12'h004, 2'd1);
    mepc = 64'h2001;
    issue(1, 2'd3, 0, 12'h060, 2'b00);
    expect_fault("R3 mret pc bit0", 2'd2, 12'h060, 2'd3);
    issue(0, 2'd0, 0, 12'h004, 2'b00);
    expect_fault("R12 priv before misalign", 2'd0, 12'h004, 2'd0);
    has_cext = 1;
    issue(0, 2'd1, 0, 12'h004, 2'b00);
    chk("R3 cext no fault", fault, 0);
    chk("R3 cext pc", ret_pc, 64'h1002);
  endtask

  task automatic t_trap_bits;  // R4 R12
    issue(0, 2'd1, 0, 12'h204, 2'b00);
    expect_fault("R4 TSR at S", 2'd0, 12'h204, 2'd1);
    issue(0, 2'd3, 0, 12'h204, 2'b00);
    chk("R4 TSR at M ok", fault, 0);
    issue(0, 2'd1, 1, 12'h004, 2'b10);
    expect_fault("R4 VTSR virt", 2'd1, 12'h004, 2'd1);
    chk("R12 virt kept", virt_out, 1);
    issue(0, 2'd1, 1, 12'h204, 2'b10);
    expect_fault("R12 TSR before VTSR", 2'd0, 12'h204, 2'd1);
    issue(0, 2'd1, 0, 12'h004, 2'b10);
    chk("R4 VTSR not virt ok", fault, 0);
  endtask

  task automatic t_pmp;  // R10
    pmp_empty = 1; mepc = 64'h100;
    issue(1, 2'd3, 0, 12'h008, 2'b00);
    expect_fault("R10 empty pmp to U", 2'd3, 12'h008, 2'd3);
    issue(1, 2'd3, 0, 12'h068, 2'b00);
    chk("R10 empty pmp to M ok", fault, 0);
    pmp_empty = 0;
  endtask

  task automatic t_elp;  // R11 R12
    cfi_en = 1; elp_in = 0;
    issue(0, 2'd1, 0, 12'h404, 2'b00);
    chk("R11 sret elp copied", elp_out, 1);
    chk("R11 SPELP cleared", mst_out[10], 0);
    cfi_en = 0; elp_in = 1;
    issue(1, 2'd3, 0, 12'h868, 2'b00);
    chk("R11 elp passthrough", elp_out, 1);
    chk("R11 MPELP cleared", mst_out[11], 0);
    elp_in = 0; cfi_en = 1;
    issue(1, 2'd1, 0, 12'h800, 2'b00);
    chk("R12 fault elp kept", elp_out, 0);
    chk("R12 fault MPELP kept", mst_out[11], 1);
    cfi_en = 0;
  endtask

  task automatic t_hold;  // R1
    logic [11:0] prev;
    prev = mst_out;
    @(negedge clk);
    mst_in = 12'hFFF; cur_priv = 2'd3;
    @(negedge clk);
    chk("R1 no done idle", done, 0);
    chk("R1 mst held", mst_out, prev);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sret_basic();
    t_sret_nohyp();
    t_mret_basic();
    t_illegal();
    t_misalign();
    t_trap_bits();
    t_pmp();
    t_elp();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule